// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a (segment register, offset) pair into a 32-bit linear address and enforces the protection rules stored in the segment's descriptor. Software loads one of `NSEG` segment registers with a 16-bit selector. The unit then decides which table to use (global or local) and checks that the selected entry lies inside that table. If it does, the unit fetches the 8-byte descriptor with two 32-bit reads over a simple request/valid memory port. It decodes the descriptor once and stores the base, the scaled limit, the write permission and the privilege level in a hidden cache slot for that register.

Every later access through that register uses only the cached copy and never touches memory. The cached limit bounds the offset, and the base is added to produce the linear address. An access that breaks a rule returns a fault code and a zero address. A single fetch engine handles loads one at a time. While it fills a register, that register is marked busy and accesses through it are held off. Accesses through the other registers continue.

The fetch engine is a four-state machine. `ST_IDLE` waits for a load. `ST_RD_LO` waits for the first descriptor word. `ST_RD_HI` waits for the second word. `ST_DONE` reports the result and writes the cache. Its transitions are:
- *accept-fetch*: `ST_IDLE` → `ST_RD_LO`, taken when the selector is usable.
- *accept-short*: `ST_IDLE` → `ST_DONE`, taken for a null selector or a table-limit violation.
- *low-word*: `ST_RD_LO` → `ST_RD_HI`, taken on the first `mem_rvalid`.
- *high-word*: `ST_RD_HI` → `ST_DONE`, taken on the second `mem_rvalid`.
- *retire*: `ST_DONE` → `ST_IDLE`, taken unconditionally.

Top module: `seg_xlate`

## Requirements
- R1: A selector is decoded as bits 15:3 = entry index, bit 2 = table choice (1 = local table, 0 = global table), bits 1:0 = requested privilege (RPL). A usable load reads the words at table base + index*8 and at table base + index*8 + 4. These are exactly two reads.
- R2: If index*8 + 7 exceeds the chosen table's 16-bit limit, no read is issued. `ld_done` then comes with `ld_code` = 2 (table limit), and the register keeps its previous cached descriptor.
- R3: A global-table selector with index 0 is null. It loads with no read and `ld_code` = 0, and any access through it returns code 1. Every register holds a null selector after reset.
- R4: Accesses use only the cached descriptor and issue no memory reads.
- R5: Descriptor layout. The first word holds limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. The second word holds base[23:16] in bits 7:0, the writable flag in bit 9, the descriptor privilege (DPL) in bits 14:13, limit[19:16] in bits 19:16, granularity in bit 23, and base[31:24] in bits 31:24.
- R6: With granularity 0, the highest legal offset equals the 20-bit limit. With granularity 1, it is limit*4096 + 4095.
- R7: An offset above the highest legal offset returns code 3 (segment limit).
- R8: A write through a segment whose writable flag is 0 returns code 4 (write protect). A read through the same segment is allowed.
- R9: An access whose cached RPL is numerically greater than the DPL returns code 5 (privilege).
- R10: `busy` has the bit of the register being loaded high from the cycle after the load is accepted until the cycle after `ld_done`. `ld_ready` is low during that time, and at most one `busy` bit is high. An access through a busy register gets no `acc_done` until the register is free. Accesses through other registers are served.
- R11: An access accepted in one cycle gives `acc_done` in the next cycle. A fault-free access has `acc_code` = 0 and `lin_addr` = base + offset. A faulting access has `lin_addr` = 0.
- R12: When several faults apply, the code is chosen in the order null, privilege, segment limit, write protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table last valid byte offset |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 16 | Local table last valid byte offset |
| load_valid | input | 1 | Load request, taken when `ld_ready` is high |
| load_seg | input | SEG_W | Segment register to load |
| load_sel | input | 16 | Selector to load |
| ld_ready | output | 1 | Fetch engine idle |
| ld_done | output | 1 | One-cycle pulse: load finished |
| ld_code | output | 3 | Load result, 0 or 2, valid with `ld_done` |
| busy | output | NSEG | Per-register fill in progress |
| mem_req | output | 1 | Read request, held until `mem_rvalid` |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| acc_valid | input | 1 | Access request |
| acc_seg | input | SEG_W | Segment register used by the access |
| acc_off | input | 32 | Offset within the segment |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_done | output | 1 | Access result valid |
| acc_code | output | 3 | Access fault code, 0 = none |
| lin_addr | output | 32 | Linear address, 0 on fault |

## Verification
Access results are due exactly one cycle after an accepted request. The bench drives a request on a falling edge and samples `acc_done`, `acc_code` and `lin_addr` on the next falling edge, after the single register stage. Load results arrive after a number of cycles that depends on the memory port. The bench therefore polls `ld_done` at falling edges with a bounded count and reads `ld_code` in that cycle. It counts `mem_rvalid` pulses to check how many reads each load or access made. During a fill, the bench holds an access to the busy register across several falling edges to show it is not answered.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic [2:0] {
        FC_NONE   = 3'd0,
        FC_NULL   = 3'd1,
        FC_TABLE  = 3'd2,
        FC_LIMIT  = 3'd3,
        FC_WRPROT = 3'd4,
        FC_PRIV   = 3'd5
    } fault_e;

    typedef struct packed {
        logic        is_null;
        logic [31:0] base;
        logic [31:0] max_off;
        logic        wr_ok;
        logic [1:0]  dpl;
        logic [1:0]  rpl;
    } seg_cache_t;

    localparam seg_cache_t NULL_ENTRY = '{is_null: 1'b1, base: '0, max_off: '0,
                                          wr_ok: 1'b0, dpl: 2'd0, rpl: 2'd0};

    // Decode the two descriptor words into a cache entry (layout in R5).
    function automatic seg_cache_t decode_desc(input logic [31:0] lo,
                                               input logic [31:0] hi,
                                               input logic [1:0]  rpl);
        seg_cache_t e;
        logic [19:0] lim;
        lim       = {hi[19:16], lo[15:0]};
        e.is_null = 1'b0;
        e.base    = {hi[31:24], hi[7:0], lo[31:16]};
        e.max_off = hi[23] ? {lim, 12'hFFF} : {12'h000, lim};
        e.wr_ok   = hi[9];
        e.dpl     = hi[14:13];
        e.rpl     = rpl;
        return e;
    endfunction

endpackage

// File: rtl/seg_fetch_fsm.sv
module seg_fetch_fsm
    import seg_xlat_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int SEG_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      gdt_base,
    input  logic [15:0]      gdt_limit,
    input  logic [31:0]      ldt_base,
    input  logic [15:0]      ldt_limit,
    input  logic             load_valid,
    input  logic [SEG_W-1:0] load_seg,
    input  logic [15:0]      load_sel,
    output logic             ld_ready,
    output logic             ld_done,
    output logic [2:0]       ld_code,
    output logic [NSEG-1:0]  busy,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             wr_en,
    output logic [SEG_W-1:0] wr_seg,
    output seg_cache_t       wr_entry
);

    typedef enum logic [1:0] {ST_IDLE, ST_RD_LO, ST_RD_HI, ST_DONE} fetch_st_e;

    fetch_st_e        state, nxt;
    logic [SEG_W-1:0] seg_q;
    logic [1:0]       rpl_q;
    logic [31:0]      addr_q, lo_q, hi_q;
    logic             skip_q, fault_q;

    logic        sel_local, sel_null, tbl_over;
    logic [15:0] byte_off, tbl_lim;
    logic [31:0] tbl_base;

    always_comb begin
        sel_local = load_sel[2];
        byte_off  = {load_sel[15:3], 3'b000};
        tbl_base  = sel_local ? ldt_base  : gdt_base;
        tbl_lim   = sel_local ? ldt_limit : gdt_limit;
        sel_null  = !sel_local && (load_sel[15:3] == 13'd0);
        tbl_over  = (byte_off | 16'h0007) > tbl_lim;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (load_valid) nxt = (sel_null || tbl_over) ? ST_DONE : ST_RD_LO;
            ST_RD_LO: if (mem_rvalid) nxt = ST_RD_HI;
            ST_RD_HI: if (mem_rvalid) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // captured load context and descriptor words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= '0; rpl_q <= '0; addr_q <= '0;
            lo_q <= '0; hi_q <= '0; skip_q <= 1'b0; fault_q <= 1'b0;
        end else begin
            if (state == ST_IDLE && load_valid) begin
                seg_q   <= load_seg;
                rpl_q   <= load_sel[1:0];
                addr_q  <= tbl_base + {16'h0000, byte_off};
                skip_q  <= sel_null;
                fault_q <= !sel_null && tbl_over;
            end
            if (state == ST_RD_LO && mem_rvalid) lo_q <= mem_rdata;
            if (state == ST_RD_HI && mem_rvalid) hi_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        ld_ready = 1'b0;
        ld_done  = 1'b0;
        ld_code  = FC_NONE;
        mem_req  = 1'b0;
        mem_addr = addr_q;
        busy     = '0;
        wr_en    = 1'b0;
        wr_seg   = seg_q;
        wr_entry = skip_q ? NULL_ENTRY : decode_desc(lo_q, hi_q, rpl_q);
        unique case (state)
            ST_IDLE:  ld_ready = 1'b1;
            ST_RD_LO: begin
                mem_req = 1'b1;
                busy[seg_q] = 1'b1;
            end
            ST_RD_HI: begin
                mem_req  = 1'b1;
                mem_addr = addr_q + 32'd4;
                busy[seg_q] = 1'b1;
            end
            ST_DONE: begin
                ld_done = 1'b1;
                ld_code = fault_q ? FC_TABLE : FC_NONE;
                wr_en   = !fault_q;
                busy[seg_q] = 1'b1;
            end
        endcase
    end

    a_r10_busy_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy));
    a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> $stable(mem_addr));
    a_r3_null_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ready && load_valid && sel_null) |=> !mem_req);
    a_r2_table_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ready && load_valid && tbl_over) |=> !mem_req);
    a_r10_free_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |=> (busy == '0 && ld_ready));

endmodule

// File: rtl/seg_cache_file.sv
module seg_cache_file
    import seg_xlat_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int SEG_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_seg,
    input  seg_cache_t       wr_entry,
    input  logic [SEG_W-1:0] rd_seg,
    output seg_cache_t       rd_entry
);

    seg_cache_t slot [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 slot[g] <= NULL_ENTRY;
            else if (wr_en && wr_seg == SEG_W'(g))      slot[g] <= wr_entry;
        end
    end

    assign rd_entry = slot[rd_seg];

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
(
    input  seg_cache_t  entry,
    input  logic [31:0] off,
    input  logic        write,
    output fault_e      code,
    output logic [31:0] addr
);

    always_comb begin
        if (entry.is_null)               code = FC_NULL;
        else if (entry.rpl > entry.dpl)  code = FC_PRIV;
        else if (off > entry.max_off)    code = FC_LIMIT;
        else if (write && !entry.wr_ok)  code = FC_WRPROT;
        else                             code = FC_NONE;
        addr = (code == FC_NONE) ? entry.base + off : 32'd0;
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlat_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int SEG_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      gdt_base,
    input  logic [15:0]      gdt_limit,
    input  logic [31:0]      ldt_base,
    input  logic [15:0]      ldt_limit,
    input  logic             load_valid,
    input  logic [SEG_W-1:0] load_seg,
    input  logic [15:0]      load_sel,
    output logic             ld_ready,
    output logic             ld_done,
    output logic [2:0]       ld_code,
    output logic [NSEG-1:0]  busy,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    input  logic             acc_valid,
    input  logic [SEG_W-1:0] acc_seg,
    input  logic [31:0]      acc_off,
    input  logic             acc_write,
    output logic             acc_done,
    output logic [2:0]       acc_code,
    output logic [31:0]      lin_addr
);

    logic             wr_en;
    logic [SEG_W-1:0] wr_seg;
    seg_cache_t       wr_entry, rd_entry;
    fault_e           chk_code;
    logic [31:0]      chk_addr;
    logic             acc_take;

    seg_fetch_fsm #(.NSEG(NSEG), .SEG_W(SEG_W)) u_fetch (
        .clk, .rst_n, .gdt_base, .gdt_limit, .ldt_base, .ldt_limit,
        .load_valid, .load_seg, .load_sel, .ld_ready, .ld_done, .ld_code,
        .busy, .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
        .wr_en, .wr_seg, .wr_entry
    );

    seg_cache_file #(.NSEG(NSEG), .SEG_W(SEG_W)) u_cache (
        .clk, .rst_n, .wr_en, .wr_seg, .wr_entry,
        .rd_seg(acc_seg), .rd_entry
    );

    seg_check u_check (
        .entry(rd_entry), .off(acc_off), .write(acc_write),
        .code(chk_code), .addr(chk_addr)
    );

    assign acc_take = acc_valid && !busy[acc_seg];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_done <= 1'b0;
            acc_code <= FC_NONE;
            lin_addr <= '0;
        end else begin
            acc_done <= acc_take;
            acc_code <= acc_take ? chk_code : FC_NONE;
            lin_addr <= acc_take ? chk_addr : 32'd0;
        end
    end

    a_r11_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> $past(acc_valid));
    a_r10_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && busy[acc_seg]) |=> !acc_done);
    a_r11_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && acc_code != 3'd0) |-> lin_addr == 32'd0);

endmodule

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;

    localparam int NSEG = 4;
    localparam int SEG_W = 2;
    localparam logic [31:0] GBASE = 32'h0000_0000;
    localparam logic [31:0] LBASE = 32'h0000_0200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [31:0] gdt_base = GBASE, ldt_base = LBASE;
    logic [15:0] gdt_limit = 16'h003F, ldt_limit = 16'h001F;
    logic load_valid = 1'b0;
    logic [SEG_W-1:0] load_seg = '0;
    logic [15:0] load_sel = '0;
    logic ld_ready, ld_done;
    logic [2:0] ld_code;
    logic [NSEG-1:0] busy;
    logic mem_req;
    logic [31:0] mem_addr;
    logic mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic acc_valid = 1'b0;
    logic [SEG_W-1:0] acc_seg = '0;
    logic [31:0] acc_off = '0;
    logic acc_write = 1'b0;
    logic acc_done;
    logic [2:0] acc_code;
    logic [31:0] lin_addr;

    int tests = 0, fails = 0, rd_cnt = 0;
    logic [31:0] mem [0:255];

    always #10 clk = ~clk;

    seg_xlate #(.NSEG(NSEG), .SEG_W(SEG_W)) uut (.*);

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_rvalid <= mem_req && !mem_rvalid;
        mem_rdata  <= mem[mem_addr[9:2]];
    end
    always @(negedge clk) if (mem_rvalid) rd_cnt++;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_desc(input logic [31:0] tb, input int idx, input logic [31:0] base,
                            input logic [19:0] lim, input logic g, input logic wr,
                            input logic [1:0] dpl);
        int w;
        w = int'((tb + 32'(idx * 8)) >> 2);
        mem[w]   = {base[15:0], lim[15:0]};
        mem[w+1] = {base[31:24], g, 3'b000, lim[19:16], 1'b1, dpl, 1'b1,
                    1'b0, 1'b0, wr, 1'b0, base[23:16]};
    endtask

    task automatic do_load(input int seg, input logic [15:0] sel,
                           output logic [2:0] code, output int reads);
        int n, r0;
        @(negedge clk);
        while (!ld_ready) @(negedge clk);
        r0 = rd_cnt;
        load_valid = 1'b1; load_seg = SEG_W'(seg); load_sel = sel;
        @(negedge clk);
        load_valid = 1'b0;
        n = 0;
        while (!ld_done && n < 20) begin @(negedge clk); n++; end
        code  = ld_done ? ld_code : 3'd7;
        reads = rd_cnt - r0;
    endtask

    task automatic do_acc(input int seg, input logic [31:0] off, input logic wr,
                          output logic done, output logic [2:0] code, output logic [31:0] addr);
        @(negedge clk);
        acc_valid = 1'b1; acc_seg = SEG_W'(seg); acc_off = off; acc_write = wr;
        @(negedge clk);
        done = acc_done; code = acc_code; addr = lin_addr;
        acc_valid = 1'b0;
    endtask

    // {seg, offset, write, code, linear address}
    localparam logic [69:0] VEC [0:9] = '{
        {2'd0, 32'h0000_0000, 1'b0, 3'd0, 32'h0010_0000},
        {2'd0, 32'h0000_0FFF, 1'b1, 3'd0, 32'h0010_0FFF},
        {2'd0, 32'h0000_1000, 1'b0, 3'd3, 32'h0000_0000},
        {2'd1, 32'h0000_2FFF, 1'b0, 3'd0, 32'h2000_2FFF},
        {2'd1, 32'h0000_3000, 1'b0, 3'd3, 32'h0000_0000},
        {2'd1, 32'h0000_0010, 1'b1, 3'd4, 32'h0000_0000},
        {2'd2, 32'h0000_0000, 1'b0, 3'd5, 32'h0000_0000},
        {2'd2, 32'h0000_0200, 1'b1, 3'd5, 32'h0000_0000},
        {2'd3, 32'h0000_FFFF, 1'b1, 3'd0, 32'h4000_FFFF},
        {2'd1, 32'h0000_3000, 1'b1, 3'd3, 32'h0000_0000}
    };

    initial begin
        #(20 * 100000);
        tests++; fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [2:0] code;
        logic [31:0] addr;
        logic done, busy_seen, early;
        int reads, r0;

        for (int i = 0; i < 256; i++) mem[i] = '0;
        set_desc(GBASE, 1, 32'h0010_0000, 20'h00FFF, 1'b0, 1'b1, 2'd3);
        set_desc(GBASE, 2, 32'h2000_0000, 20'h00002, 1'b1, 1'b0, 2'd3);
        set_desc(GBASE, 3, 32'h0000_5000, 20'h000FF, 1'b0, 1'b1, 2'd1);
        set_desc(LBASE, 1, 32'h4000_0000, 20'h0FFFF, 1'b0, 1'b1, 2'd3);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset busy", 64'(busy), 64'h0);
        chk("R10 reset ld_ready", 64'(ld_ready), 64'h1);
        do_acc(0, 32'h0, 1'b0, done, code, addr);
        chk("R3 reset null code", {done, code}, {1'b1, 3'd1});

        // R1 two reads per usable load, global and local tables
        do_load(0, 16'h000B, code, reads);
        chk("R1 load seg0 code", 64'(code), 64'h0);
        chk("R1 load seg0 reads", 64'(reads), 64'd2);
        do_load(1, 16'h0010, code, reads);
        chk("R1 load seg1 code", 64'(code), 64'h0);
        do_load(2, 16'h001B, code, reads);
        chk("R1 load seg2 code", 64'(code), 64'h0);
        do_load(3, 16'h000C, code, reads);
        chk("R1 load local seg3", {code, 8'(reads)}, {3'd0, 8'd2});

        // vector walk: R4 R5 R6 R7 R8 R9 R11 R12
        r0 = rd_cnt;
        for (int i = 0; i < 10; i++) begin
            do_acc(int'(VEC[i][69:68]), VEC[i][67:36], VEC[i][35], done, code, addr);
            chk($sformatf("R11 vec%0d done", i), 64'(done), 64'h1);
            chk($sformatf("R7 R8 R9 R12 vec%0d code", i), 64'(code), 64'(VEC[i][34:32]));
            chk($sformatf("R5 R6 vec%0d addr", i), 64'(addr), 64'(VEC[i][31:0]));
        end
        chk("R4 no reads during accesses", 64'(rd_cnt - r0), 64'd0);

        // R2 table limit: global index 8, local index 4; seg0 keeps its entry
        do_load(0, 16'h0040, code, reads);
        chk("R2 global over code", {code, 8'(reads)}, {3'd2, 8'd0});
        do_acc(0, 32'h10, 1'b0, done, code, addr);
        chk("R2 seg0 unchanged", {code, addr}, {3'd0, 32'h0010_0010});
        do_load(3, 16'h0024, code, reads);
        chk("R2 local over code", {code, 8'(reads)}, {3'd2, 8'd0});

        // R3 null load into seg2
        do_load(2, 16'h0003, code, reads);
        chk("R3 null load", {code, 8'(reads)}, {3'd0, 8'd0});
        do_acc(2, 32'h0, 1'b0, done, code, addr);
        chk("R3 null access", {code, addr}, {3'd1, 32'h0});

        // R10 stall during a fill of seg1, other register served
        @(negedge clk);
        load_valid = 1'b1; load_seg = 2'd1; load_sel = 16'h0010;
        @(negedge clk);
        load_valid = 1'b0;
        busy_seen = busy[1] && !ld_ready;
        acc_valid = 1'b1; acc_seg = 2'd1; acc_off = 32'h0; acc_write = 1'b0;
        early = 1'b0;
        repeat (2) begin @(negedge clk); if (acc_done) early = 1'b1; end
        chk("R10 busy during fill", 64'(busy_seen), 64'h1);
        chk("R10 busy register stalls", 64'(early), 64'h0);
        acc_seg = 2'd0;
        @(negedge clk);
        chk("R10 other register served", {acc_done, acc_code, lin_addr},
            {1'b1, 3'd0, 32'h0010_0000});
        acc_valid = 1'b0;
        while (!ld_done) @(negedge clk);
        do_acc(1, 32'h0000_0100, 1'b0, done, code, addr);
        chk("R10 seg1 after fill", {done, code, addr}, {1'b1, 3'd0, 32'h2000_0100});

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule